// File: doc/BRIEF.md
# Memory Self-Test Pattern Engine

This block exercises an external memory without processor help. It puts a sequence of word transactions on a simple request/acknowledge memory port. The address starts at zero and rises by one word per beat. In a write test every beat carries a fixed data pattern. In a read test every returned word is compared against that pattern, and the mismatches are counted in a saturating error counter. The memory timing protocol and the physical layer are handled elsewhere.

The host sets several configuration inputs:
- a self-test enable;
- single or burst framing;
- write or read direction;
- a 2-bit pattern selector;
- the number of words per burst;
- the number of bursts.

The host then pulses `start`, waits for `test_done` and reads `err_count`. All configuration is captured when a start is accepted. Changes to the inputs while a run is in progress therefore have no effect on that run.

Top module: `mem_bist_engine`

## Requirements
- R1: After reset, `mem_req` is 0, `test_done` is 0 and `err_count` is 0.
- R2: While `cfg_selftest` is 0, a `start` pulse is ignored. No request is raised, and `test_done` and `err_count` keep their values.
- R3: A run issues exactly `cfg_bursts` × (words per burst) beats. Word addresses go 0, 1, 2, … in order. `mem_we` is 1 for a write test and 0 for a read test.
- R4: `cfg_pattern` selects the word as follows. 0 gives 32'hAAAA5555, 1 gives 32'h5555AAAA, 2 gives the word address zero-extended, and 3 gives all zeros. In a write test this word is driven on `mem_wdata`.
- R5: In a read test, each acknowledged beat whose `mem_rdata` differs from the selected pattern word for that address adds one to `err_count`.
- R6: `err_count` saturates at all ones and never wraps.
- R7: In burst framing, `mem_first` is 1 only on the first beat of each burst and `mem_last` only on its final beat. In single framing, both are 1 on every beat.
- R8: A words-per-burst value of 0 is treated as 1.
- R9: A run with `cfg_bursts` = 0 issues no beat and sets `test_done` on the edge that accepts the start.
- R10: An accepted start clears `err_count` and `test_done` on the same edge. `test_done` rises on the edge after which the final beat was acknowledged.
- R11: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady until `mem_ack` is seen.
- R12: A `start` pulse or a configuration change during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_selftest | input | 1 | 1 = self-test mode, 0 = normal operation (start ignored) |
| cfg_burst | input | 1 | 1 = burst framing, 0 = single accesses |
| cfg_read | input | 1 | 1 = read test, 0 = write test |
| cfg_pattern | input | 2 | Pattern selector |
| cfg_beats | input | BEAT_W | Words per burst (0 behaves as 1) |
| cfg_bursts | input | CNT_W | Number of bursts in a run |
| start | input | 1 | Start command, sampled on the clock edge |
| mem_req | output | 1 | Beat request |
| mem_we | output | 1 | 1 = write beat |
| mem_first | output | 1 | First beat of a transaction |
| mem_last | output | 1 | Final beat of a transaction |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Beat accepted by the memory; read data valid |
| mem_rdata | input | DATA_W | Read data |
| err_count | output | ERR_W | Saturating mismatch counter |
| test_done | output | 1 | End-of-run flag |

## Verification
The bench builds the engine with an 8-bit address, a 16-bit burst count and a 4-bit error counter. The narrow counter lets one read run of 20 mismatching words drive it into saturation, which the default 30-bit width would never reach in simulation. The 8-bit address keeps the address-as-data pattern and the memory model small.

The sweep covers:
- every pattern;
- both framings;
- several burst shapes;
- write runs, clean read runs, and read runs with injected bit flips.

For each read run, the bench computes the expected mismatch count from the pattern pair and the set of corrupted addresses. The memory acknowledge stalls on a repeating pattern, so both back-to-back beats and held requests occur.

// File: rtl/mem_bist_pkg.sv
package mem_bist_pkg;

    typedef enum logic [1:0] {
        PAT_CHECKER = 2'd0,
        PAT_INVERT  = 2'd1,
        PAT_ADDRESS = 2'd2,
        PAT_ZERO    = 2'd3
    } pat_e;

    localparam logic [31:0] CHECKER_WORD = 32'hAAAA5555;

endpackage

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen
    import mem_bist_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24
) (
    input  pat_e              mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);

    logic [DATA_W-1:0] base;

    // replicate the 32-bit checker word across the data width
    for (genvar g = 0; g < DATA_W; g++) begin : g_base
        assign base[g] = CHECKER_WORD[g % 32];
    end

    always_comb begin
        unique case (mode)
            PAT_CHECKER: word = base;
            PAT_INVERT:  word = ~base;
            PAT_ADDRESS: word = DATA_W'(addr);
            default:     word = '0;
        endcase
    end

endmodule

// File: rtl/bist_sequencer.sv
module bist_sequencer
    import mem_bist_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BEAT_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              selftest_en,
    input  logic              cfg_burst,
    input  logic              cfg_read,
    input  pat_e              cfg_pat,
    input  logic [BEAT_W-1:0] cfg_beats,
    input  logic [CNT_W-1:0]  cfg_bursts,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic              accept,
    output logic              read_mode,
    output pat_e              pat,
    output logic [ADDR_W-1:0] addr,
    output logic              first,
    output logic              last
);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              read;
        logic              burst_mode;
        pat_e              pat;
        logic [BEAT_W-1:0] beats;
        logic [BEAT_W-1:0] beat;
        logic [CNT_W-1:0]  bursts;
        logic [CNT_W-1:0]  burst;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t s_d, s_q;
    logic burst_end, run_end;

    assign burst_end = (s_q.beat == s_q.beats - 1'b1);
    assign run_end   = (s_q.burst == s_q.bursts - 1'b1);
    assign accept    = start && selftest_en && !s_q.busy;

    always_comb begin
        s_d = s_q;
        if (accept) begin
            s_d.busy       = (cfg_bursts != '0);
            s_d.done       = (cfg_bursts == '0);
            s_d.read       = cfg_read;
            s_d.burst_mode = cfg_burst;
            s_d.pat        = cfg_pat;
            s_d.beats      = (cfg_beats == '0) ? BEAT_W'(1) : cfg_beats;
            s_d.beat       = '0;
            s_d.bursts     = cfg_bursts;
            s_d.burst      = '0;
            s_d.addr       = '0;
        end else if (s_q.busy && mem_ack) begin
            s_d.addr = s_q.addr + 1'b1;
            if (burst_end) begin
                s_d.beat = '0;
                if (run_end) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.burst = s_q.burst + 1'b1;
                end
            end else begin
                s_d.beat = s_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign done      = s_q.done;
    assign read_mode = s_q.read;
    assign pat       = s_q.pat;
    assign addr      = s_q.addr;
    assign first     = s_q.burst_mode ? (s_q.beat == '0) : 1'b1;
    assign last      = s_q.burst_mode ? burst_end : 1'b1;

endmodule

// File: rtl/bist_err_acc.sv
module bist_err_acc #(
    parameter int DATA_W = 32,
    parameter int ERR_W  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expect_word,
    output logic [ERR_W-1:0]  err
);

    logic [ERR_W-1:0] err_d, err_q;
    logic             miss;

    assign miss = sample && (rdata != expect_word);

    always_comb begin
        err_d = err_q;
        if (clear)                      err_d = '0;
        else if (miss && (err_q != '1)) err_d = err_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign err = err_q;

endmodule

// File: rtl/mem_bist_engine.sv
module mem_bist_engine
    import mem_bist_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int BEAT_W = 8,
    parameter int CNT_W  = 32,
    parameter int ERR_W  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_selftest,
    input  logic              cfg_burst,
    input  logic              cfg_read,
    input  logic [1:0]        cfg_pattern,
    input  logic [BEAT_W-1:0] cfg_beats,
    input  logic [CNT_W-1:0]  cfg_bursts,
    input  logic              start,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_first,
    output logic              mem_last,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ERR_W-1:0]  err_count,
    output logic              test_done
);

    logic              busy, accept, read_mode;
    pat_e              run_pat;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] pat_word;

    bist_sequencer #(
        .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .selftest_en(cfg_selftest),
        .cfg_burst  (cfg_burst),
        .cfg_read   (cfg_read),
        .cfg_pat    (pat_e'(cfg_pattern)),
        .cfg_beats  (cfg_beats),
        .cfg_bursts (cfg_bursts),
        .mem_ack    (mem_ack),
        .busy       (busy),
        .done       (test_done),
        .accept     (accept),
        .read_mode  (read_mode),
        .pat        (run_pat),
        .addr       (addr),
        .first      (mem_first),
        .last       (mem_last)
    );

    bist_pattern_gen #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_pat (
        .mode(run_pat),
        .addr(addr),
        .word(pat_word)
    );

    bist_err_acc #(
        .DATA_W(DATA_W), .ERR_W(ERR_W)
    ) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .sample     (busy && mem_ack && read_mode),
        .rdata      (mem_rdata),
        .expect_word(pat_word),
        .err        (err_count)
    );

    assign mem_req   = busy;
    assign mem_we    = !read_mode;
    assign mem_addr  = addr;
    assign mem_wdata = pat_word;

endmodule

// File: rtl/mem_bist_engine_chk.sv
module mem_bist_engine_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int ERR_W  = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cfg_selftest,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [ERR_W-1:0]  err_count,
    input logic              test_done
);

    // R11: request and its payload wait for the acknowledge
    a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_wdata) && $stable(mem_we)));

    // R3: consecutive beats step the address by one word
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (!mem_req || mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R10: the end flag is never raised while beats are pending
    a_r10_done_excl_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !test_done);

    // R6: without a start the counter never decreases (no wrap)
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (err_count >= $past(err_count)));

    // R2: self-test off keeps the port idle
    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_selftest && !mem_req) |=> !mem_req);

endmodule

bind mem_bist_engine mem_bist_engine_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cfg_selftest(cfg_selftest),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .err_count   (err_count),
    .test_done   (test_done)
);

// File: tb/mem_bist_engine_tb.sv
module mem_bist_engine_tb;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int BEAT_W = 8;
    localparam int CNT_W  = 16;
    localparam int ERR_W  = 4;
    localparam int ERR_MAX = (1 << ERR_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_selftest = 1'b0, cfg_burst = 1'b0, cfg_read = 1'b0;
    logic [1:0]        cfg_pattern = 2'd0;
    logic [BEAT_W-1:0] cfg_beats = '0;
    logic [CNT_W-1:0]  cfg_bursts = '0;
    logic              start = 1'b0;
    logic              mem_req, mem_we, mem_first, mem_last;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [ERR_W-1:0]  err_count;
    logic              test_done;

    always #4 clk = ~clk;

    mem_bist_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W),
        .CNT_W(CNT_W), .ERR_W(ERR_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_selftest(cfg_selftest),
        .cfg_burst(cfg_burst), .cfg_read(cfg_read), .cfg_pattern(cfg_pattern),
        .cfg_beats(cfg_beats), .cfg_bursts(cfg_bursts), .start(start),
        .mem_req(mem_req), .mem_we(mem_we), .mem_first(mem_first),
        .mem_last(mem_last), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .err_count(err_count),
        .test_done(test_done)
    );

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string tag,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat_word(input int p, input int a);
        case (p)
            0: return 32'hAAAA5555;
            1: return 32'h5555AAAA;
            2: return 32'(a & 8'hFF);
            default: return 32'h0;
        endcase
    endfunction

    // expectations of the current run, owned by the run task
    int  exp_pat, exp_beats, exp_burst_mode, exp_read;
    bit  corrupt = 1'b0;
    // monitor bookkeeping
    int  seen = 0;
    int  mon_beat = 0;
    int  ack_ctr = 0;
    logic [31:0] mem [256];

    always @(negedge clk) begin
        logic ack_now;
        ack_ctr++;
        ack_now = (ack_ctr % 3) != 2;
        mem_rdata = mem[mem_addr] ^ ((corrupt && (mem_addr % 5 == 3)) ? 32'h1 : 32'h0);
        mem_ack = ack_now;
        if (mem_req && ack_now && rst_n) begin
            check(mem_addr == ADDR_W'(seen), "R3 address order", mem_addr, seen);
            check(mem_we == !exp_read, "R3 direction", mem_we, !exp_read);
            check(mem_first == (exp_burst_mode ? (mon_beat == 0) : 1'b1),
                  "R7 first flag", mem_first, mon_beat);
            check(mem_last == (exp_burst_mode ? (mon_beat == exp_beats - 1) : 1'b1),
                  "R7 last flag", mem_last, mon_beat);
            if (!exp_read) begin
                check(mem_wdata == pat_word(exp_pat, seen), "R4 write data",
                      mem_wdata, pat_word(exp_pat, seen));
                mem[mem_addr] = mem_wdata;
            end
            seen++;
            mon_beat = (mon_beat == exp_beats - 1) ? 0 : mon_beat + 1;
        end
    end

    // one accepted run; disturb != 0 pulses start and changes config mid-run (R12)
    task automatic run(input bit burst, input bit rd, input int p, input int beats,
                       input int bursts, input int exp_err, input bit disturb);
        int eff, total, n;
        eff = (beats == 0) ? 1 : beats;
        total = eff * bursts;
        @(negedge clk);
        cfg_selftest = 1'b1; cfg_burst = burst; cfg_read = rd;
        cfg_pattern = 2'(p); cfg_beats = BEAT_W'(beats); cfg_bursts = CNT_W'(bursts);
        exp_pat = p; exp_beats = eff; exp_burst_mode = burst; exp_read = rd;
        seen = 0; mon_beat = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (bursts != 0) begin
            check(test_done == 1'b0, "R10 start clears done", test_done, 0);
            check(err_count == 0, "R10 start clears errors", err_count, 0);
        end
        if (disturb) begin
            repeat (3) @(negedge clk);
            cfg_pattern = 2'(p + 1); cfg_read = !rd; cfg_burst = !burst;
            cfg_beats = 8'd7; cfg_bursts = 16'd9;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!test_done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(test_done == 1'b1, "R10 done after final beat", test_done, 1);
        check(seen == total, "R3 beat count", seen, total);
        check(err_count == ERR_W'(exp_err), "R5 error count", err_count, exp_err);
        check(mem_req == 1'b0, "R10 idle after done", mem_req, 0);
    endtask

    function automatic int read_errs(input int wp, input int rp, input int total,
                                     input bit corr);
        int e = 0;
        for (int a = 0; a < total; a++) begin
            logic [31:0] got;
            got = pat_word(wp, a) ^ ((corr && (a % 5 == 3)) ? 32'h1 : 32'h0);
            if (got != pat_word(rp, a)) e++;
        end
        return (e > ERR_MAX) ? ERR_MAX : e;
    endfunction

    initial begin
        int bt_list [2] = '{1, 3};
        int bc_list [2] = '{1, 4};
        repeat (5) @(negedge clk);
        check(mem_req == 1'b0, "R1 reset request", mem_req, 0);
        check(test_done == 1'b0, "R1 reset done", test_done, 0);
        check(err_count == 0, "R1 reset errors", err_count, 0);
        rst_n = 1'b1;

        // R2: start ignored in normal operation
        seen = 0;
        @(negedge clk);
        cfg_selftest = 1'b0; cfg_bursts = 16'd2; cfg_beats = 8'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check(seen == 0, "R2 no beats when off", seen, 0);
        check(mem_req == 1'b0, "R2 port idle when off", mem_req, 0);
        check(test_done == 1'b0, "R2 done unchanged", test_done, 0);
        check(err_count == 0, "R2 errors unchanged", err_count, 0);

        // sweep of patterns, framings and shapes (R3 R4 R5 R7)
        for (int p = 0; p < 4; p++)
            for (int bm = 0; bm < 2; bm++)
                for (int i = 0; i < 2; i++)
                    for (int j = 0; j < 2; j++) begin
                        int tot;
                        tot = bt_list[i] * bc_list[j];
                        corrupt = 1'b0;
                        run(bm[0], 1'b0, p, bt_list[i], bc_list[j], 0, 1'b0);
                        run(bm[0], 1'b1, p, bt_list[i], bc_list[j], 0, 1'b0);
                        corrupt = 1'b1;
                        run(bm[0], 1'b1, p, bt_list[i], bc_list[j],
                            read_errs(p, p, tot, 1'b1), 1'b0);
                        corrupt = 1'b0;
                    end

        // R8: zero words per burst behaves as one
        run(1'b1, 1'b0, 0, 0, 3, 0, 1'b0);

        // R9: zero bursts finishes at once
        @(negedge clk);
        cfg_selftest = 1'b1; cfg_bursts = '0; cfg_beats = 8'd4;
        seen = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(test_done == 1'b1, "R9 done on accept", test_done, 1);
        check(mem_req == 1'b0, "R9 no request", mem_req, 0);
        repeat (3) @(negedge clk);
        check(seen == 0, "R9 no beats", seen, 0);

        // R6: saturation with a narrow counter
        run(1'b1, 1'b0, 0, 4, 5, 0, 1'b0);
        run(1'b1, 1'b1, 1, 4, 5, read_errs(0, 1, 20, 1'b0), 1'b0);
        check(err_count == ERR_W'(ERR_MAX), "R6 saturated", err_count, ERR_MAX);

        // R12: mid-run start and config changes are ignored
        run(1'b1, 1'b0, 2, 3, 4, 0, 1'b1);
        run(1'b0, 1'b1, 2, 3, 4, 0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule